// File: doc/BRIEF.md
# UART Byte FIFO with DMA Request Generation

This block is a byte queue placed between a serial UART engine and whatever moves data to and from memory, whether a processor or a DMA controller. A parameter picks the direction the instance serves. A receive instance is filled by the engine and emptied by the bus side. A transmit instance is filled by the bus side and emptied by the engine. A trigger select input sets a fill threshold in eighths of the depth. The threshold drives a level interrupt and a burst DMA request. A second DMA request, the single request, says whether one more byte can be moved.

When the FIFO-enable input is low, the queue holds at most one byte. In that mode it works as a plain holding register, which gives the classic double-buffered UART interface. Any change of the enable input discards the stored contents. Writes to a full queue are dropped and set a sticky overrun flag. Reads from an empty queue leave the data output and the occupancy unchanged.

Top module: `uart_dma_fifo`

## Requirements
- R1: Bytes leave in the order they were accepted. The byte removed by a pop appears on `pop_data` one clock after the pop and stays there until the next accepted pop. The default depth is 16 entries of 8 bits.
- R2: `level` gives the number of bytes held. `empty` is high when `level` is 0. `full` is high when `level` equals the capacity, which is 16 with the FIFO enabled.
- R3: A push while full and with no pop in the same cycle is dropped and sets `overrun`. `overrun` then stays high until reset.
- R4: A pop while empty changes neither `pop_data` nor `level`.
- R5: A push and a pop in the same cycle on a non-empty queue leave `level` unchanged. This also holds when the queue is full, and the pushed byte is kept.
- R6: The trigger threshold is set by `trig_sel`: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12, 4 gives 14. The values 5 to 7 behave as 2 (half depth).
- R7: Receive instance: `dma_single` is high when `level` is at least 1. `dma_burst` and `irq` are both high when `level` is at or above the threshold.
- R8: Transmit instance: `dma_single` is high when `level` is below the capacity. `dma_burst` and `irq` are both high when `level` is at or below the threshold.
- R9: With `fifo_en` low, the capacity is 1 and `trig_sel` is ignored. The receive threshold becomes 1 and the transmit threshold becomes 0.
- R10: In a cycle where `fifo_en` differs from its value in the previous cycle, the queue is emptied. A push or pop in that cycle has no effect, and `overrun` is not changed.
- R11: After reset, the queue is empty, `overrun` is 0, `pop_data` is 0, and the enable input is taken to have been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: full-depth queue, 0: one-byte holding register |
| trig_sel | input | 3 | Trigger threshold select |
| push | input | 1 | Write strobe |
| push_data | input | 8 | Byte to write |
| pop | input | 1 | Read strobe |
| pop_data | output | 8 | Last byte read |
| full | output | 1 | Queue at capacity |
| empty | output | 1 | Queue holds no byte |
| level | output | 5 | Bytes held |
| overrun | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Level interrupt (trigger comparison) |
| dma_single | output | 1 | Single-transfer DMA request |
| dma_burst | output | 1 | Burst DMA request |

## Verification
The assertions assume that `push` and `pop` are clean, synchronous strobes that are valid at every clock edge after reset. They also assume that `fifo_en` and `trig_sel` are held for whole cycles. The bench drives every input shortly after a rising edge and holds it for a full period. It changes `fifo_en` only through the same per-cycle driver task, so the design and the bench model see every change of the enable in the same cycle. Full-queue pushes, empty-queue pops and enable changes made while data is held are all produced on purpose. These are the conditions the overrun, hold and flush properties depend on.

// File: rtl/uart_dma_fifo.sv
module uart_dma_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter bit IS_TX = 1'b0,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [2:0]       trig_sel,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    level,
  output logic             overrun,
  output logic             irq,
  output logic             dma_single,
  output logic             dma_burst
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt, cap, thr;
  logic             en_q, mode_chg, do_push, do_pop, trig_hit;

  assign mode_chg = fifo_en != en_q;
  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  assign full     = cnt >= cap;
  assign empty    = cnt == '0;
  assign level    = cnt;
  assign do_pop   = pop && !empty && !mode_chg;
  assign do_push  = push && (!full || do_pop) && !mode_chg;

  always_comb begin
    if (!fifo_en) thr = IS_TX ? CW'(0) : CW'(1);
    else begin
      case (trig_sel)
        3'd0:    thr = CW'(DEPTH / 8);
        3'd1:    thr = CW'(DEPTH / 4);
        3'd3:    thr = CW'(DEPTH * 3 / 4);
        3'd4:    thr = CW'(DEPTH * 7 / 8);
        default: thr = CW'(DEPTH / 2);
      endcase
    end
  end

  assign trig_hit   = IS_TX ? (cnt <= thr) : (cnt >= thr);
  assign irq        = trig_hit;
  assign dma_burst  = trig_hit;
  assign dma_single = IS_TX ? !full : !empty;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      overrun  <= 1'b0;
      pop_data <= '0;
      en_q     <= 1'b1;
    end else begin
      en_q <= fifo_en;
      if (mode_chg) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        cnt    <= '0;
      end else begin
        if (push && !do_push) overrun <= 1'b1;
        if (do_push) wr_ptr <= nxt(wr_ptr);
        if (do_pop) begin
          rd_ptr   <= nxt(rd_ptr);
          pop_data <= mem[rd_ptr];
        end
        if (do_push && !do_pop) cnt <= cnt + 1'b1;
        else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  p_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |-> level <= cap);
  p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !mode_chg |=> overrun);
  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push && !mode_chg |=> $stable(pop_data) && level == '0);
  p_pushpop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !empty && !mode_chg |=> $stable(level));
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> empty);

endmodule

// File: tb/sim_uart_dma_fifo.sv
module sim_uart_dma_fifo;
  logic clk = 0, rst_n = 0, fifo_en = 1, push = 0, pop = 0;
  logic [2:0] trig_sel = 0;
  logic [7:0] push_data = 0, pd0, pd1;
  logic f0, e0, o0, i0, s0, b0, f1, e1, o1, i1, s1, b1;
  logic [4:0] l0, l1;
  int total = 0, bad = 0;
  logic [7:0] q[$];
  bit movr = 0, men_q = 1, chk_pend = 0;
  logic [7:0] chk_val;

  always #10 clk = ~clk;

  uart_dma_fifo #(.IS_TX(1'b0)) u0 (.clk, .rst_n, .fifo_en, .trig_sel, .push, .push_data, .pop,
    .pop_data(pd0), .full(f0), .empty(e0), .level(l0), .overrun(o0), .irq(i0), .dma_single(s0), .dma_burst(b0));
  uart_dma_fifo #(.IS_TX(1'b1)) u1 (.clk, .rst_n, .fifo_en, .trig_sel, .push, .push_data, .pop,
    .pop_data(pd1), .full(f1), .empty(e1), .level(l1), .overrun(o1), .irq(i1), .dma_single(s1), .dma_burst(b1));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cap_m();
    return fifo_en ? 16 : 1;
  endfunction

  function automatic int thr_m(input bit tx);
    if (!fifo_en) return tx ? 0 : 1;
    case (trig_sel)
      3'd0: return 2;
      3'd1: return 4;
      3'd3: return 12;
      3'd4: return 14;
      default: return 8;
    endcase
  endfunction

  task automatic check_flags();
    int sz = q.size();
    string t7 = fifo_en ? "R7" : "R9";
    string t8 = fifo_en ? "R8" : "R9";
    chk("R2", int'(l0), sz);
    chk("R2", int'(l1), sz);
    chk("R2", int'({f0, e0}), int'({sz >= cap_m(), sz == 0}));
    chk("R3", int'({o0, o1}), int'({movr, movr}));
    chk(t7, int'({s0, b0, i0}), int'({sz != 0, sz >= thr_m(0), sz >= thr_m(0)}));
    chk(t8, int'({s1, b1, i1}), int'({sz < cap_m(), sz <= thr_m(1), sz <= thr_m(1)}));
  endtask

  task automatic step(input bit ps, input logic [7:0] d, input bit pp);
    bit dp, dw;
    push = ps; push_data = d; pop = pp;
    @(posedge clk); #1;
    if (fifo_en != men_q) q.delete();
    else begin
      dp = pp && q.size() > 0;
      dw = ps && (q.size() < cap_m() || dp);
      if (ps && !dw) movr = 1;
      if (dp) begin chk_val = q.pop_front(); chk_pend = 1; end
      if (dw) q.push_back(d);
    end
    men_q = fifo_en;
    push = 0; pop = 0;
    check_flags();
  endtask

  always @(negedge clk) begin
    if (chk_pend) begin
      chk("R1", int'(pd0), int'(chk_val));
      chk("R1", int'(pd1), int'(chk_val));
      chk_pend = 0;
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] last;
    #35; rst_n = 1; #1;
    chk("R11", int'({e0, o0, l0}), int'({1'b1, 1'b0, 5'd0}));
    chk("R11", int'(pd0), 0);
    check_flags();
    // R1 R2 R6 R7 R8: fill and drain under every trigger select
    for (int t = 0; t < 8; t++) begin
      trig_sel = 3'(t);
      for (int i = 0; i < 16; i++) step(1, 8'(t * 16 + i + 1), 0);
      for (int i = 0; i < 16; i++) step(0, 0, 1);
    end
    // R4: pop while empty keeps data and level
    last = pd0;
    step(0, 0, 1); step(0, 0, 1);
    chk("R4", int'(pd0), int'(last));
    chk("R4", int'(l0), 0);
    // R3: overrun on full
    trig_sel = 4;
    for (int i = 0; i < 16; i++) step(1, 8'(8'h40 + i), 0);
    step(1, 8'hEE, 0);
    step(1, 8'hEF, 0);
    chk("R3", int'(o0), 1);
    // R5: push and pop together at full and at partial fill
    step(1, 8'h77, 1);
    chk("R5", int'(l0), 16);
    for (int i = 0; i < 11; i++) step(0, 0, 1);
    step(1, 8'h78, 1); step(1, 8'h79, 1);
    chk("R5", int'(l0), 5);
    for (int i = 0; i < 5; i++) step(0, 0, 1);
    // R10: enable change flushes, strobes ignored
    step(1, 8'h11, 0); step(1, 8'h12, 0);
    fifo_en = 0;
    step(1, 8'h13, 1);
    chk("R10", int'({e0, l0}), int'({1'b1, 5'd0}));
    // R9: bypass holding register, trig_sel ignored
    for (int t = 0; t < 8; t += 3) begin
      trig_sel = 3'(t);
      step(1, 8'hA0 + 8'(t), 0);
      chk("R9", int'(f0), 1);
      step(1, 8'hB0, 0);
      step(0, 0, 1);
      step(1, 8'hC0, 1);
      step(0, 0, 1);
    end
    fifo_en = 1;
    step(0, 0, 0);
    chk("R10", int'({f0, e0}), int'({1'b0, 1'b1}));
    for (int i = 0; i < 20; i++) step(1, 8'(i * 7), (i % 3) == 0);
    for (int i = 0; i < 18; i++) step(0, 0, 1);
    #5;
    finish_run();
  end
endmodule